// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a processor against runaway software and can double as a periodic tick source. A hidden 16-bit up-counter advances on one of two clock-enable strobes: a fast system tick or a slow auxiliary tick. One of four counter bits serves as the expiry tap. Software cannot read or load the counter. It steers the counter only through a 16-bit control word, and a write to that word is accepted only when its upper byte carries the write key 0x5A. Reads of the control word always return 0x69 in the upper byte.

A small sequencer decides what an expiry means. It has three states. `S_WDOG` is the armed watchdog. `S_ITIMER` is interval-timer operation. `S_BITE` is the single cycle in which a reset request is raised.

The sequencer moves as follows:
- `S_WDOG` goes to `S_BITE` on an expiry or on a write with a bad key. It goes to `S_ITIMER` when the mode bit is set.
- `S_ITIMER` goes back to `S_WDOG` when the mode bit is cleared.
- `S_BITE` stays in `S_BITE` if a new trigger arrives. Otherwise it returns to the state the mode bit selects.

In timer mode an expiry sets a sticky interrupt flag, and software clears the flag on a separate input.

Top module: `guard_timer`

## Requirements
- R1: After reset the control low byte is 0x00: watchdog mode, system tick, tap bit 15, no hold. `rd_data` reads 0x6900, and `rst_req` and `irq_flag` are 0.
- R2: A write whose upper byte is 0x5A stores these low-byte bits: 7 hold, 6 ext_edge, 5 ext_en, 4 mode, 2 source, 1:0 tap. Reads return 0x69 in the upper byte and 0 in bit 3.
- R3: A write with any other upper byte changes no stored bit. In watchdog mode it raises `rst_req` for one cycle after that write edge. In timer mode it raises nothing.
- R4: The tap field sets the interval, counted in selected ticks from a cleared counter: 00 gives 2^15, 01 gives 2^13, 10 gives 2^9, 11 gives 2^6.
- R5: Source bit 2 = 0 counts `sys_tick` and source bit 2 = 1 counts `aux_tick`. The unselected strobe has no effect.
- R6: While hold (bit 7) is 1, the counter does not advance. When hold is cleared, counting resumes from the held value.
- R7: In watchdog mode, the edge on which the counter completes the interval raises `rst_req` for exactly one cycle and restarts the counter at zero, so the next bite comes one full interval later.
- R8: In timer mode, an expiry sets `irq_flag`, which stays set, and never raises `rst_req`. The counter keeps running, so expiries repeat every interval.
- R9: `irq_clr` clears `irq_flag` on the next edge. If an expiry happens on the same edge, the flag is set.
- R10: An accepted write with bit 3 = 1 restarts the counter at zero on that edge, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Write data: key byte in [15:8], control bits in [7:0] |
| rd_data | output | 16 | Control-word readback |
| sys_tick | input | 1 | Fast count enable |
| aux_tick | input | 1 | Slow count enable |
| irq_clr | input | 1 | Clears the interval flag |
| rst_req | output | 1 | Reset request pulse |
| irq_flag | output | 1 | Sticky interval flag |

## Verification
The assertions assume that `wr_en`, `wr_data`, `irq_clr` and both tick strobes are synchronous to `clk` and settle before each rising edge. They also assume that a tick counts once for each edge on which it is high. The stimulus changes every input one nanosecond after a rising edge and holds it through the next edge. Each write lasts exactly one cycle. Ticks are driven as levels, so the expected counts are whole edge counts measured from the write edge that cleared the counter.

// File: rtl/gt_pkg.sv
package gt_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] KEY_WR = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_RD = 8'h69;

    // control bit positions, fixed because software decodes them
    localparam int unsigned B_HOLD = 7;
    localparam int unsigned B_EDGE = 6;
    localparam int unsigned B_EEN  = 5;
    localparam int unsigned B_MODE = 4;
    localparam int unsigned B_CLR  = 3;
    localparam int unsigned B_SRC  = 2;
    localparam int unsigned B_TAP  = 0;

    typedef enum logic [1:0] {
        S_WDOG   = 2'd0,
        S_ITIMER = 2'd1,
        S_BITE   = 2'd2
    } gt_state_e;

    typedef struct packed {
        logic       hold;
        logic       ext_edge;
        logic       ext_en;
        logic       mode;
        logic       src;
        logic [1:0] tap;
    } gt_ctrl_t;

endpackage

// File: rtl/gt_regs.sv
module gt_regs
    import gt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output gt_ctrl_t          ctrl_o,
    output logic              clr_o,
    output logic              key_bad_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned KEY_LO = DATA_W - BYTE_W;

    gt_ctrl_t ctrl_q;
    logic     key_ok;
    logic     wr_ok;

    assign key_ok    = (wr_data_i[DATA_W-1:KEY_LO] == KEY_WR);
    assign wr_ok     = wr_en_i && key_ok;
    assign key_bad_o = wr_en_i && !key_ok;
    assign clr_o     = wr_ok && wr_data_i[B_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ok) begin
            ctrl_q.hold     <= wr_data_i[B_HOLD];
            ctrl_q.ext_edge <= wr_data_i[B_EDGE];
            ctrl_q.ext_en   <= wr_data_i[B_EEN];
            ctrl_q.mode     <= wr_data_i[B_MODE];
            ctrl_q.src      <= wr_data_i[B_SRC];
            ctrl_q.tap      <= wr_data_i[B_TAP+1:B_TAP];
        end
    end

    assign ctrl_o    = ctrl_q;
    assign rd_data_o = {KEY_RD, ctrl_q.hold, ctrl_q.ext_edge, ctrl_q.ext_en,
                        ctrl_q.mode, 1'b0, ctrl_q.src, ctrl_q.tap};

    // R3: a rejected key leaves every stored bit alone
    p_bad_key_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad_o |=> (ctrl_q == $past(ctrl_q)));

    // R2: an accepted write lands the mode and tap bits
    p_key_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (ctrl_q.mode == $past(wr_data_i[B_MODE]))
              && (ctrl_q.tap == $past(wr_data_i[B_TAP+1:B_TAP])));

endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TAP_0 = 15,
    parameter int unsigned TAP_1 = 13,
    parameter int unsigned TAP_2 = 9,
    parameter int unsigned TAP_3 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_tick_i,
    input  logic       aux_tick_i,
    input  logic       hold_i,
    input  logic       src_i,
    input  logic [1:0] tap_i,
    input  logic       clr_i,
    input  logic       bite_clr_i,
    output logic       expire_o
);

    localparam int unsigned N_TAP = 4;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [N_TAP-1:0] flip;
    logic             tick;

    assign tick    = !hold_i && (src_i ? aux_tick_i : sys_tick_i);
    assign cnt_inc = cnt_q + 1'b1;

    // a tap expires whenever its bit toggles on an increment,
    // which happens once every 2^tap ticks
    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        localparam int unsigned TP = (g == 0) ? TAP_0 :
                                     (g == 1) ? TAP_1 :
                                     (g == 2) ? TAP_2 : TAP_3;
        assign flip[g] = cnt_q[TP] ^ cnt_inc[TP];
    end

    assign expire_o = tick && flip[tap_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || bite_clr_i) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_inc;
        end
    end

    // R6: hold freezes the count
    p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i && !bite_clr_i) |=> (cnt_q == $past(cnt_q)));

    // R10: the clear bit restarts at zero
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R5: the unselected strobe never moves the count
    p_src_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !bite_clr_i && ((src_i && !aux_tick_i) || (!src_i && !sys_tick_i)))
        |=> (cnt_q == $past(cnt_q)));

    // R7: a bite leaves the counter at zero
    p_bite_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bite_clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/gt_fsm.sv
module gt_fsm
    import gt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic expire_i,
    input  logic key_bad_i,
    input  logic irq_clr_i,
    output logic bite_clr_o,
    output logic rst_req_o,
    output logic irq_o
);

    gt_state_e state_q;
    gt_state_e state_d;
    logic      trig;
    logic      irq_set;
    logic      irq_q;

    assign trig = expire_i || key_bad_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WDOG;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WDOG: begin
                if (trig)        state_d = S_BITE;
                else if (mode_i) state_d = S_ITIMER;
            end
            S_ITIMER: begin
                if (!mode_i)     state_d = S_WDOG;
            end
            S_BITE: begin
                if (trig)        state_d = S_BITE;
                else if (mode_i) state_d = S_ITIMER;
                else             state_d = S_WDOG;
            end
            default:             state_d = S_WDOG;
        endcase
    end

    always_comb begin
        rst_req_o  = (state_q == S_BITE);
        bite_clr_o = expire_i && (state_q != S_ITIMER);
        irq_set    = expire_i && (state_q == S_ITIMER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (irq_set) begin
            irq_q <= 1'b1;
        end else if (irq_clr_i) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

    // R7: a watchdog expiry bites on the next cycle
    p_wd_bite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WDOG && expire_i) |=> rst_req_o);

    // R7: the request lasts one cycle without a new trigger
    p_bite_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !trig) |=> !rst_req_o);

    // R3: a rejected key in watchdog mode bites
    p_bad_key_bite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WDOG && key_bad_i) |=> rst_req_o);

    // R8: timer operation never requests reset
    p_timer_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ITIMER) |=> !rst_req_o);

    // R8: the flag is sticky
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q);

    // R9: set beats clear; clear alone empties the flag
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ITIMER && expire_i) |=> irq_q);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !(state_q == S_ITIMER && expire_i)) |=> !irq_q);

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TAP_0 = 15,
    parameter int unsigned TAP_1 = 13,
    parameter int unsigned TAP_2 = 9,
    parameter int unsigned TAP_3 = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        sys_tick,
    input  logic        aux_tick,
    input  logic        irq_clr,
    output logic        rst_req,
    output logic        irq_flag
);

    gt_ctrl_t ctrl;
    logic     clr;
    logic     key_bad;
    logic     expire;
    logic     bite_clr;

    gt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .ctrl_o    (ctrl),
        .clr_o     (clr),
        .key_bad_o (key_bad),
        .rd_data_o (rd_data)
    );

    gt_counter #(
        .CNT_W (CNT_W),
        .TAP_0 (TAP_0),
        .TAP_1 (TAP_1),
        .TAP_2 (TAP_2),
        .TAP_3 (TAP_3)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_tick_i (sys_tick),
        .aux_tick_i (aux_tick),
        .hold_i     (ctrl.hold),
        .src_i      (ctrl.src),
        .tap_i      (ctrl.tap),
        .clr_i      (clr),
        .bite_clr_i (bite_clr),
        .expire_o   (expire)
    );

    gt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (ctrl.mode),
        .expire_i   (expire),
        .key_bad_i  (key_bad),
        .irq_clr_i  (irq_clr),
        .bite_clr_o (bite_clr),
        .rst_req_o  (rst_req),
        .irq_o      (irq_flag)
    );

    // R1: readback always carries the read key
    p_read_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[15:8] == 8'h69) && !rd_data[3]);

endmodule

// File: tb/guard_timer_tb_top.sv
module guard_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        sys_tick;
    logic        aux_tick;
    logic        irq_clr;
    logic        rst_req;
    logic        irq_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    guard_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sys_tick (sys_tick),
        .aux_tick (aux_tick),
        .irq_clr  (irq_clr),
        .rst_req  (rst_req),
        .irq_flag (irq_flag)
    );

    // {config low byte, interval in ticks}
    localparam int NV = 6;
    localparam logic [24:0] VEC [NV] = '{
        {8'h03, 17'd64},
        {8'h02, 17'd512},
        {8'h01, 17'd8192},
        {8'h07, 17'd64},
        {8'h13, 17'd64},
        {8'h16, 17'd512}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic run(input int n, output int bites);
        bites = 0;
        for (int k = 0; k < n; k++) begin
            step();
            if (rst_req) bites++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
    end

    initial begin
        int b;
        logic [7:0] cfg;
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        sys_tick = 1'b1; aux_tick = 1'b0; irq_clr = 1'b0;
        repeat (3) step();
        chk("R1 readback after reset", rd_data, 16'h6900);
        chk("R1 rst_req after reset", rst_req, 0);
        chk("R1 irq_flag after reset", irq_flag, 0);
        rst_n = 1'b1;

        // table walk: R4 intervals, R7 watchdog, R8 timer, R5 source
        for (int i = 0; i < NV; i++) begin
            cfg = VEC[i][24:17];
            n   = int'(VEC[i][16:0]);
            sys_tick = !cfg[2];
            aux_tick = cfg[2];
            wr({8'h5A, cfg | 8'h08});
            run(n - 1, b);
            chk("R4 no early expiry (bites)", b, 0);
            chk("R4 no early expiry (irq)", irq_flag, 0);
            step();
            if (!cfg[4]) begin
                chk("R7 watchdog bite at interval", rst_req, 1);
                step();
                chk("R7 request lasts one cycle", rst_req, 0);
                run(n - 2, b);
                chk("R7 restart, no bite before next interval", b, 0);
                step();
                chk("R7 second bite one interval later", rst_req, 1);
            end else begin
                chk("R8 timer flag set at interval", irq_flag, 1);
                chk("R8 timer never bites", rst_req, 0);
                irq_clr = 1'b1; step(); irq_clr = 1'b0;
                chk("R9 irq_clr empties flag", irq_flag, 0);
                run(n - 2, b);
                chk("R8 no bite while timing", b, 0);
                chk("R8 flag stays clear mid-interval", irq_flag, 0);
                step();
                chk("R8 counter kept running, flag again", irq_flag, 1);
                irq_clr = 1'b1; step(); irq_clr = 1'b0;
            end
        end
        sys_tick = 1'b1; aux_tick = 1'b0;

        // R2: keyed write and readback
        wr(16'h5A75);
        chk("R2 readback of stored bits", rd_data, 16'h6975);
        wr(16'h5A7D);
        chk("R2 bit 3 reads zero", rd_data, 16'h6975);
        // R3: bad key in timer mode
        wr(16'h1234);
        chk("R3 bad key keeps bits", rd_data, 16'h6975);
        chk("R3 bad key in timer mode no bite", rst_req, 0);

        // R3: bad key in watchdog mode
        wr(16'h5A0B);
        step();
        wr(16'hA5FF);
        chk("R3 bad key in watchdog bites", rst_req, 1);
        chk("R3 bad key keeps bits (wd)", rd_data, 16'h6903);
        step();
        chk("R3 violation pulse one cycle", rst_req, 0);

        // R10: clear bit restarts the count
        wr(16'h5A0B);
        repeat (40) step();
        wr(16'h5A0B);
        run(63, b);
        chk("R10 no bite at old deadline", b, 0);
        step();
        chk("R10 bite one interval after clear", rst_req, 1);

        // R6: hold
        wr(16'h5A8B);
        run(200, b);
        chk("R6 held counter never bites", b, 0);
        wr(16'h5A03);
        run(63, b);
        chk("R6 resume from held zero, no early bite", b, 0);
        step();
        chk("R6 bite after release", rst_req, 1);

        // R5: unselected strobe ignored
        wr(16'h5A0F);
        sys_tick = 1'b1; aux_tick = 1'b0;
        run(200, b);
        chk("R5 system tick ignored when aux selected", b, 0);
        sys_tick = 1'b0; aux_tick = 1'b1;
        run(63, b);
        chk("R5 aux count no early bite", b, 0);
        step();
        chk("R5 aux count bites at interval", rst_req, 1);
        sys_tick = 1'b1; aux_tick = 1'b0;

        // R9: set beats a simultaneous clear
        wr(16'h5A1B);
        repeat (63) step();
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk("R9 set wins over clear", irq_flag, 1);
        chk("R8 timer expiry no bite", rst_req, 0);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk("R9 clear afterwards", irq_flag, 0);

        // R1/R4: default tap 2^15 after reset
        rst_n = 1'b0;
        step();
        chk("R1 reset clears flag and request", {irq_flag, rst_req}, 0);
        chk("R1 reset restores control", rd_data, 16'h6900);
        rst_n = 1'b1;
        run(32767, b);
        chk("R4 default tap no early bite", b, 0);
        step();
        chk("R4 default tap bites at 2^15", rst_req, 1);

        summary();
    end

endmodule